// File: doc/BRIEF.md
# Operand Address Generator for an 8-bit Accumulator CPU

This unit turns the addressing-mode part of an opcode into the location of the operand. The caller hands over the opcode's two group bits, its three mode bits, a flag that swaps X indexing for Y indexing, the access direction, both index registers and the program counter. The unit then fetches whatever operand bytes and pointer bytes the mode needs through a byte-wide synchronous read port, one read per clock.

It returns one of four things:
- a 16-bit memory address;
- a select telling the caller to take the accumulator;
- a select telling the caller to take the immediate byte, whose address it also reports;
- an illegal-mode indication.

Along with this it returns a page-penalty flag for indexed reads that cross a page, and the program counter advanced past the operand bytes.

Requests enter on a valid/ready pair. `req_ready` is high only while the unit is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result leaves on a second valid/ready pair. While `res_valid` is high and `res_ready` is low, every result output holds its value and no new request is accepted. The memory port has no back-pressure: the byte for a read issued in one cycle must be on `mem_rd_data` in the next.

Top module: `opnd_addr_unit`

## Requirements
- R1: In group 01 the mode bits decode as follows:
  - 000: zero-page pointer indexed by X first.
  - 001: zero page.
  - 010: immediate.
  - 011: absolute.
  - 100: zero-page pointer with Y added afterwards.
  - 101: zero page plus X.
  - 110: absolute plus Y.
  - 111: absolute plus X.
- R2: Group 00 has immediate at 000, zero page at 001, absolute at 011, zero page plus X at 101 and absolute plus X at 111. Codes 010, 100 and 110 are illegal.
- R3: Group 10 decodes like group 00, except that 010 selects the accumulator with no memory read. Codes 100 and 110 are illegal.
  - Group 11 is illegal for every code.
  - An illegal result has `res_illegal`=1, `res_sel`=3 and `res_addr`=0, and it does not move the program counter.
- R4: With `req_yswap`=1 in group 10, code 101 becomes zero page plus Y and code 111 becomes absolute plus Y. In the other groups `req_yswap` has no effect on any result.
- R5: Zero-page indexed modes add the index to the low byte only. The address high byte is always 0x00, so the address wraps inside page zero.
- R6: Absolute-indexed modes and the Y-post-indexed pointer mode add the index to the full 16-bit base, so a carry reaches the high byte.
- R7: The X-pre-indexed mode reads its pointer low byte at ((operand + X) mod 256) and its high byte at ((operand + X + 1) mod 256), both in page zero. The Y-post-indexed mode reads its pointer at operand and at (operand + 1) mod 256, then adds Y. Multi-byte values are little-endian, low byte first.
- R8: `res_penalty` is 1 only when all three hold:
  - the access is a read (`req_write`=0);
  - the mode is absolute plus X, absolute plus Y or Y-post-indexed;
  - the index addition carries out of the low address byte.
- R9: `res_sel` is 0 for a memory address, 1 for the accumulator, 2 for immediate and 3 for illegal.
  - Immediate reports the address of the immediate byte, which is the incoming program counter.
  - `res_pc` is the incoming program counter plus 0 for accumulator or illegal, plus 1 for immediate, zero-page and pointer modes, and plus 2 for absolute modes.
- R10: `req_ready` is high only while idle. A held result keeps all result outputs stable until it is taken with `res_ready`.
- R11: After reset `req_ready`=1, `res_valid`=0 and `mem_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and accepting |
| req_grp | input | 2 | Opcode group bits |
| req_mode | input | 3 | Opcode mode bits |
| req_yswap | input | 1 | Use Y in place of X in group 10 |
| req_write | input | 1 | Access is a write |
| req_x | input | 8 | X index register |
| req_y | input | 8 | Y index register |
| req_pc | input | 16 | Address of the first operand byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read byte, valid one cycle after the strobe |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Caller takes the result |
| res_addr | output | 16 | Effective address |
| res_sel | output | 2 | Operand source select |
| res_illegal | output | 1 | Mode code is illegal |
| res_penalty | output | 1 | Extra cycle owed for a page crossing on a read |
| res_pc | output | 16 | Program counter after the operand bytes |

## Verification
Two things meet in the same result cycle: the index carry that moves the address into the next page, and the write-intent gating of the penalty flag. The bench sends the same absolute-plus-X and Y-post-indexed requests with a crossing base, once as a read and once as a write. It expects the same carried address both times, with the penalty flag set only on the read. A second case pairs a low-byte carry with the zero-page wrap, where the carry must be dropped and no penalty raised.

// File: rtl/oa_pkg.sv
package oa_pkg;
  typedef enum logic [3:0] {
    M_IMM, M_ZP, M_ZPX, M_ZPY, M_ABS, M_ABX, M_ABY, M_IZX, M_IZY, M_ACC, M_BAD
  } mode_e;

  typedef enum logic [1:0] {
    SEL_MEM = 2'd0, SEL_ACC = 2'd1, SEL_IMM = 2'd2, SEL_NONE = 2'd3
  } sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_OP, S_WT_OP, S_WT_HI, S_RD_PTR, S_WT_PLO, S_WT_PHI, S_FIN, S_DONE
  } st_e;
endpackage

// File: rtl/oa_mode_decode.sv
module oa_mode_decode
  import oa_pkg::*;
(
  input  logic [1:0] grp,
  input  logic [2:0] code,
  input  logic       yswap,
  output mode_e      mode
);
  always_comb begin
    mode = M_BAD;
    unique case (grp)
      2'b01: begin
        unique case (code)
          3'd0: mode = M_IZX;
          3'd1: mode = M_ZP;
          3'd2: mode = M_IMM;
          3'd3: mode = M_ABS;
          3'd4: mode = M_IZY;
          3'd5: mode = M_ZPX;
          3'd6: mode = M_ABY;
          default: mode = M_ABX;
        endcase
      end
      2'b00: begin
        case (code)
          3'd0: mode = M_IMM;
          3'd1: mode = M_ZP;
          3'd3: mode = M_ABS;
          3'd5: mode = M_ZPX;
          3'd7: mode = M_ABX;
          default: mode = M_BAD;
        endcase
      end
      2'b10: begin
        case (code)
          3'd0: mode = M_IMM;
          3'd1: mode = M_ZP;
          3'd2: mode = M_ACC;
          3'd3: mode = M_ABS;
          3'd5: mode = yswap ? M_ZPY : M_ZPX;
          3'd7: mode = yswap ? M_ABY : M_ABX;
          default: mode = M_BAD;
        endcase
      end
      default: mode = M_BAD;
    endcase
  end
endmodule

// File: rtl/oa_index_add.sv
module oa_index_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx,
  input  logic            zp_wrap,
  output logic [2*DW-1:0] sum,
  output logic            carry_lo
);
  logic [DW:0]   lo_add;
  logic [DW-1:0] hi_inc;

  always_comb begin
    lo_add   = {1'b0, base[DW-1:0]} + {1'b0, idx};
    hi_inc   = base[2*DW-1:DW] + {{(DW-1){1'b0}}, lo_add[DW]};
    carry_lo = lo_add[DW];
    sum      = zp_wrap ? {{DW{1'b0}}, lo_add[DW-1:0]} : {hi_inc, lo_add[DW-1:0]};
  end
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oa_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_grp,
  input  logic [2:0]    req_mode,
  input  logic          req_yswap,
  input  logic          req_write,
  input  logic [DW-1:0] req_x,
  input  logic [DW-1:0] req_y,
  input  logic [AW-1:0] req_pc,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_addr,
  output logic [1:0]    res_sel,
  output logic          res_illegal,
  output logic          res_penalty,
  output logic [AW-1:0] res_pc
);
  localparam logic [DW-1:0] ZPAGE = '0;

  st_e           st;
  mode_e         dec_mode, mode_q;
  logic          wr_q;
  logic [DW-1:0] x_q, y_q, lo_q, hi_q, plo_q, phi_q;
  logic [AW-1:0] pc_q;

  logic [AW-1:0] addr_q, pcn_q;
  sel_e          sel_q;
  logic          ill_q, pen_q;

  oa_mode_decode u_dec (
    .grp  (req_grp),
    .code (req_mode),
    .yswap(req_yswap),
    .mode (dec_mode)
  );

  // pointer location in page zero; X applies only to the pre-indexed form
  logic [DW-1:0] zp_ptr;
  logic          is_abs;
  assign zp_ptr = lo_q + ((mode_q == M_IZX) ? x_q : ZPAGE);
  assign is_abs = (mode_q == M_ABS) || (mode_q == M_ABX) || (mode_q == M_ABY);

  // final address formation
  logic [AW-1:0] base_sel, ea_sum, pc_adv;
  logic [DW-1:0] idx_sel;
  logic          zp_wrap, carry_lo;
  sel_e          sel_n;

  always_comb begin
    idx_sel  = '0;
    base_sel = '0;
    pc_adv   = '0;
    sel_n    = SEL_MEM;
    unique case (mode_q)
      M_ZPX, M_ABX:        idx_sel = x_q;
      M_ZPY, M_ABY, M_IZY: idx_sel = y_q;
      default:             idx_sel = '0;
    endcase
    unique case (mode_q)
      M_ZP, M_ZPX, M_ZPY:   base_sel = {ZPAGE, lo_q};
      M_ABS, M_ABX, M_ABY:  base_sel = {hi_q, lo_q};
      M_IZX, M_IZY:         base_sel = {phi_q, plo_q};
      M_IMM:                base_sel = pc_q;
      default:              base_sel = '0;
    endcase
    unique case (mode_q)
      M_ABS, M_ABX, M_ABY:                      pc_adv = AW'(2);
      M_IMM, M_ZP, M_ZPX, M_ZPY, M_IZX, M_IZY:  pc_adv = AW'(1);
      default:                                  pc_adv = '0;
    endcase
    unique case (mode_q)
      M_IMM:   sel_n = SEL_IMM;
      M_ACC:   sel_n = SEL_ACC;
      M_BAD:   sel_n = SEL_NONE;
      default: sel_n = SEL_MEM;
    endcase
  end

  assign zp_wrap = (mode_q == M_ZPX) || (mode_q == M_ZPY);

  oa_index_add #(.DW(DW)) u_add (
    .base    (base_sel),
    .idx     (idx_sel),
    .zp_wrap (zp_wrap),
    .sum     (ea_sum),
    .carry_lo(carry_lo)
  );

  // memory read port
  always_comb begin
    mem_rd_en = 1'b0;
    mem_addr  = '0;
    case (st)
      S_RD_OP: begin
        mem_rd_en = 1'b1;
        mem_addr  = pc_q;
      end
      S_WT_OP: if (is_abs) begin
        mem_rd_en = 1'b1;
        mem_addr  = pc_q + AW'(1);
      end
      S_RD_PTR: begin
        mem_rd_en = 1'b1;
        mem_addr  = {ZPAGE, zp_ptr};
      end
      S_WT_PLO: begin
        mem_rd_en = 1'b1;
        mem_addr  = {ZPAGE, zp_ptr + DW'(1)};
      end
      default: ;
    endcase
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= M_BAD;
      wr_q   <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      pc_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
      addr_q <= '0;
      pcn_q  <= '0;
      sel_q  <= SEL_NONE;
      ill_q  <= 1'b0;
      pen_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          mode_q <= dec_mode;
          wr_q   <= req_write;
          x_q    <= req_x;
          y_q    <= req_y;
          pc_q   <= req_pc;
          st     <= (dec_mode == M_IMM || dec_mode == M_ACC || dec_mode == M_BAD)
                    ? S_FIN : S_RD_OP;
        end
        S_RD_OP: st <= S_WT_OP;
        S_WT_OP: begin
          lo_q <= mem_rd_data;
          if (is_abs)                                   st <= S_WT_HI;
          else if (mode_q == M_IZX || mode_q == M_IZY)  st <= S_RD_PTR;
          else                                          st <= S_FIN;
        end
        S_WT_HI: begin
          hi_q <= mem_rd_data;
          st   <= S_FIN;
        end
        S_RD_PTR: st <= S_WT_PLO;
        S_WT_PLO: begin
          plo_q <= mem_rd_data;
          st    <= S_WT_PHI;
        end
        S_WT_PHI: begin
          phi_q <= mem_rd_data;
          st    <= S_FIN;
        end
        S_FIN: begin
          addr_q <= ea_sum;
          pcn_q  <= pc_q + pc_adv;
          sel_q  <= sel_n;
          ill_q  <= (mode_q == M_BAD);
          pen_q  <= !wr_q && carry_lo &&
                    (mode_q == M_ABX || mode_q == M_ABY || mode_q == M_IZY);
          st     <= S_DONE;
        end
        S_DONE: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign res_valid   = (st == S_DONE);
  assign res_addr    = addr_q;
  assign res_sel     = sel_q;
  assign res_illegal = ill_q;
  assign res_penalty = pen_q;
  assign res_pc      = pcn_q;

  // R8: a write never owes the page penalty
  a_r8_no_penalty_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && wr_q |-> !res_penalty);

  // R3: an illegal code leaves the program counter where it was
  a_r3_illegal_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> (res_pc == pc_q) && (res_sel == SEL_NONE));

  // R5: zero-page forms never leave page zero
  a_r5_zero_page_high: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY)
    |-> res_addr[AW-1:DW] == ZPAGE);

  // R9: the program counter moves by at most two operand bytes
  a_r9_pc_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pc - pc_q) <= AW'(2));

  // R10: a held result stays put until taken
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_pc)
    && $stable(res_sel) && $stable(res_penalty));

  // R10: idle means no result pending and no read in flight
  a_r10_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_rd_en);
endmodule

// File: tb/opnd_addr_unit_tb_top.sv
module opnd_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_grp = '0;
  logic [2:0]  req_mode = '0;
  logic        req_yswap = 1'b0, req_write = 1'b0;
  logic [7:0]  req_x = '0, req_y = '0;
  logic [15:0] req_pc = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        res_valid, res_ready = 1'b1;
  logic [15:0] res_addr, res_pc;
  logic [1:0]  res_sel;
  logic        res_illegal, res_penalty;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  opnd_addr_unit dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_grp, .req_mode, .req_yswap,
    .req_write, .req_x, .req_y, .req_pc, .mem_rd_en, .mem_addr, .mem_rd_data,
    .res_valid, .res_ready, .res_addr, .res_sel, .res_illegal, .res_penalty, .res_pc
  );

  // sparse memory: a few forced bytes over a computed pattern
  logic [15:0] ov_a [8];
  logic [7:0]  ov_d [8];
  int          ov_n = 0;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) return ov_d[i];
    return (a[7:0] ^ {a[11:8], a[15:12]}) + 8'h3C;
  endfunction

  task automatic set_mem(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a; ov_d[ov_n] = d; ov_n++;
  endtask

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model taken from the requirement text
  task automatic model(input logic [1:0] g, input logic [2:0] c, input logic ys,
                       input logic wr, input logic [7:0] x, input logic [7:0] y,
                       input logic [15:0] pc, output logic [15:0] ea,
                       output logic [1:0] sel, output logic ill,
                       output logic pen, output logic [15:0] npc);
    string m;
    logic [7:0] op, zp;
    logic [15:0] base, ptr;
    m = "bad";
    if (g == 2'b01) begin
      case (c)
        0: m = "izx"; 1: m = "zp"; 2: m = "imm"; 3: m = "abs";
        4: m = "izy"; 5: m = "zpx"; 6: m = "aby"; default: m = "abx";
      endcase
    end else if (g == 2'b00 || g == 2'b10) begin
      case (c)
        0: m = "imm"; 1: m = "zp"; 3: m = "abs";
        5: m = (g == 2'b10 && ys) ? "zpy" : "zpx";
        7: m = (g == 2'b10 && ys) ? "aby" : "abx";
        2: m = (g == 2'b10) ? "acc" : "bad";
        default: m = "bad";
      endcase
    end
    op   = mem_byte(pc);
    base = {mem_byte(pc + 16'd1), op};
    ea = 16'h0; sel = 2'd0; ill = 1'b0; pen = 1'b0; npc = pc;
    case (m)
      "imm": begin ea = pc; sel = 2'd2; npc = pc + 16'd1; end
      "acc": begin sel = 2'd1; end
      "zp":  begin ea = {8'h00, op}; npc = pc + 16'd1; end
      "zpx": begin ea = {8'h00, op + x}; npc = pc + 16'd1; end
      "zpy": begin ea = {8'h00, op + y}; npc = pc + 16'd1; end
      "abs": begin ea = base; npc = pc + 16'd2; end
      "abx": begin ea = base + x; pen = !wr && ({1'b0, base[7:0]} + x > 9'hFF); npc = pc + 16'd2; end
      "aby": begin ea = base + y; pen = !wr && ({1'b0, base[7:0]} + y > 9'hFF); npc = pc + 16'd2; end
      "izx": begin
        zp = op + x;
        ea = {mem_byte({8'h00, zp + 8'd1}), mem_byte({8'h00, zp})};
        npc = pc + 16'd1;
      end
      "izy": begin
        ptr = {mem_byte({8'h00, op + 8'd1}), mem_byte({8'h00, op})};
        ea = ptr + y; pen = !wr && ({1'b0, ptr[7:0]} + y > 9'hFF); npc = pc + 16'd1;
      end
      default: begin sel = 2'd3; ill = 1'b1; end
    endcase
  endtask

  task automatic do_req(input logic [1:0] g, input logic [2:0] c, input logic ys,
                        input logic wr, input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] pc);
    int w;
    @(negedge clk);
    req_valid = 1'b1; req_grp = g; req_mode = c; req_yswap = ys;
    req_write = wr; req_x = x; req_y = y; req_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!res_valid && w < 40) begin @(negedge clk); w++; end
    if (!res_valid) begin
      n_chk++; n_bad++;
      $display("FAIL R10: no result got 0 expected 1");
    end
  endtask

  task automatic cmp_req(input string tag, input logic [1:0] g, input logic [2:0] c,
                         input logic ys, input logic wr, input logic [7:0] x,
                         input logic [7:0] y, input logic [15:0] pc);
    logic [15:0] ea, npc;
    logic [1:0]  sel;
    logic        ill, pen;
    model(g, c, ys, wr, x, y, pc, ea, sel, ill, pen, npc);
    do_req(g, c, ys, wr, x, y, pc);
    chk($sformatf("%s addr g%0d c%0d", tag, g, c), res_addr, ea);
    chk($sformatf("%s sel g%0d c%0d", tag, g, c), res_sel, sel);
    chk($sformatf("%s illegal g%0d c%0d", tag, g, c), res_illegal, ill);
    chk($sformatf("R8 penalty g%0d c%0d", g, c), res_penalty, pen);
    chk($sformatf("R9 pc g%0d c%0d", g, c), res_pc, npc);
  endtask

  task automatic t_reset;
    chk("R11 req_ready", req_ready, 1);
    chk("R11 res_valid", res_valid, 0);
    chk("R11 mem_rd_en", mem_rd_en, 0);
  endtask

  // R1 R2 R3: every code in every group, reads and writes
  task automatic t_tables;
    for (int g = 0; g < 4; g++)
      for (int c = 0; c < 8; c++) begin
        string tg;
        tg = (g == 1) ? "R1" : (g == 0) ? "R2" : "R3";
        cmp_req(tg, 2'(g), 3'(c), 1'b0, 1'(c & 1), 8'(17 * c + 3),
                8'(29 * c + 200), 16'(16'h3100 + 16'(g * 64 + c * 5)));
      end
  endtask

  // R4: Y swap in group 10, and no effect elsewhere
  task automatic t_yswap;
    for (int g = 0; g < 4; g++)
      for (int c = 0; c < 8; c++)
        cmp_req("R4", 2'(g), 3'(c), 1'b1, 1'b0, 8'h11, 8'hE7,
                16'(16'h5200 + 16'(c * 3)));
  endtask

  // R5: zero-page wrap, carry dropped and no penalty
  task automatic t_zp_wrap;
    ov_n = 0;
    set_mem(16'h6000, 8'hF0);
    do_req(2'b10, 3'd5, 1'b1, 1'b0, 8'h00, 8'h25, 16'h6000);
    chk("R5 zp+y wrap addr", res_addr, 16'h0015);
    chk("R8 zp wrap no penalty", res_penalty, 0);
    do_req(2'b01, 3'd5, 1'b0, 1'b0, 8'h20, 8'h00, 16'h6000);
    chk("R5 zp+x wrap addr", res_addr, 16'h0010);
    ov_n = 0;
  endtask

  // R6 R8: crossing absolute index, read then write
  task automatic t_page_cross;
    ov_n = 0;
    set_mem(16'h7001, 8'hF0);
    set_mem(16'h7002, 8'h12);
    do_req(2'b01, 3'd7, 1'b0, 1'b0, 8'h20, 8'h00, 16'h7001);
    chk("R6 abs+x carry addr", res_addr, 16'h1310);
    chk("R8 abs+x read penalty", res_penalty, 1);
    chk("R9 abs pc", res_pc, 16'h7003);
    do_req(2'b01, 3'd7, 1'b0, 1'b1, 8'h20, 8'h00, 16'h7001);
    chk("R6 abs+x write addr", res_addr, 16'h1310);
    chk("R8 abs+x write no penalty", res_penalty, 0);
    do_req(2'b01, 3'd6, 1'b0, 1'b0, 8'h00, 8'h05, 16'h7001);
    chk("R8 abs+y no cross", res_penalty, 0);
    chk("R6 abs+y addr", res_addr, 16'h12F5);
    ov_n = 0;
  endtask

  // R7: pointer forms, including pointer wrap at the top of page zero
  task automatic t_pointers;
    ov_n = 0;
    set_mem(16'h4000, 8'hFE);
    set_mem(16'h00FF, 8'h34);
    set_mem(16'h0000, 8'h12);
    do_req(2'b01, 3'd0, 1'b0, 1'b0, 8'h01, 8'h00, 16'h4000);
    chk("R7 x-pre pointer wrap", res_addr, 16'h1234);
    chk("R9 pointer pc", res_pc, 16'h4001);
    ov_n = 0;
    set_mem(16'h4100, 8'h80);
    set_mem(16'h0080, 8'hFF);
    set_mem(16'h0081, 8'h20);
    do_req(2'b01, 3'd4, 1'b0, 1'b0, 8'h00, 8'h01, 16'h4100);
    chk("R7 y-post carry addr", res_addr, 16'h2100);
    chk("R8 y-post read penalty", res_penalty, 1);
    do_req(2'b01, 3'd4, 1'b0, 1'b1, 8'h00, 8'h01, 16'h4100);
    chk("R8 y-post write no penalty", res_penalty, 0);
    ov_n = 0;
  endtask

  // R10: result held under back-pressure
  task automatic t_backpressure;
    logic [15:0] a0, p0;
    res_ready = 1'b0;
    do_req(2'b01, 3'd3, 1'b0, 1'b0, 8'h00, 8'h00, 16'h2222);
    a0 = res_addr; p0 = res_pc;
    repeat (5) @(negedge clk);
    chk("R10 held valid", res_valid, 1);
    chk("R10 held addr", res_addr, a0);
    chk("R10 held pc", res_pc, p0);
    chk("R10 busy not ready", req_ready, 0);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", res_valid, 0);
    chk("R10 ready again", req_ready, 1);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_tables();
    t_yswap();
    t_zp_wrap();
    t_page_cross();
    t_pointers();
    t_backpressure();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule